// File: doc/BRIEF.md
# Socket Buffer Partition and Pointer Unit

This block carves an 8 KB transmit window (byte addresses 0x4000 to 0x5FFF) and an 8 KB receive window (0x6000 to 0x7FFF) of a 32 KB network-controller buffer space into one slice per socket. Two byte-wide size-configuration registers set the slices, one for transmit and one for receive. The slices are packed back to back, starting at socket 0. Each slice size is a power of two, so every pointer is reduced to a slice offset by masking it with size-1.

From the per-socket 16-bit read and write pointers, the block gives the free room in each transmit slice as a combinational value. The amount of received data in each receive slice is held in a register, and that register is reloaded only when the socket's receive-acknowledge command pulses. A translation port turns a chosen socket's pointer into a physical buffer address. The buffer RAM and the data movement sit outside this block. Restoring a saved state means writing the stored size bytes back, and the slices are then derived again from those bytes.

Top module: `sockbuf_map`

## Requirements
- R1: After reset both size registers hold 0x55. Every socket then has a 2 KB slice in each window: transmit bases 0x4000, 0x4800, 0x5000, 0x5800 and receive bases 0x6000, 0x6800, 0x7000, 0x7800. All received-size registers read 0.
- R2: A write with `cfg_addr` = 0x001A loads the receive size register and a write with `cfg_addr` = 0x001B loads the transmit size register. Writes to any other address change no output. The new partition appears on the outputs in the cycle after the write edge.
- R3: Socket i's size field is bits [2i+1:2i] of its size register. Field values 0, 1, 2 and 3 give slice sizes of 1024, 2048, 4096 and 8192 bytes.
- R4: Socket 0's base is the window start. The base of socket i+1 is the base of socket i plus the size of socket i.
- R5: A socket whose packed base would lie at or beyond the window end (0x6000 for transmit, 0x8000 for receive) gets size 0. Its reported base is the window end. A socket whose base lies inside the window keeps its full requested size.
- R6: Transmit free room is size − ((wr − rd) mod size), using the masked pointers. It is combinational and is 0 for a size-0 socket.
- R7: When `recv_cmd[i]` is high at a clock edge, socket i's received size is loaded with (rx_wr − rx_rd) mod size, or 0 for a size-0 socket. Otherwise it holds its value. Sockets load independently.
- R8: `xlat_addr` = base + (`xlat_ptr` & (size−1)) for the socket `xlat_sel` in the window picked by `xlat_rx` (0 transmit, 1 receive). For a size-0 socket it is the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| tx_rd_ptr | input | 64 | Transmit read pointers, socket i in bits [16i+15:16i] |
| tx_wr_ptr | input | 64 | Transmit write pointers |
| rx_rd_ptr | input | 64 | Receive read pointers |
| rx_wr_ptr | input | 64 | Receive write pointers |
| recv_cmd | input | 4 | Per-socket receive-acknowledge pulse |
| xlat_sel | input | 2 | Socket chosen for translation |
| xlat_rx | input | 1 | Translation window: 0 transmit, 1 receive |
| xlat_ptr | input | 16 | Pointer to translate |
| tx_base | output | 64 | Transmit slice bases |
| tx_size | output | 64 | Transmit slice sizes in bytes |
| rx_base | output | 64 | Receive slice bases |
| rx_size | output | 64 | Receive slice sizes in bytes |
| tx_free | output | 64 | Transmit free room per socket |
| rx_rsr | output | 64 | Registered received size per socket |
| xlat_addr | output | 16 | Physical buffer address |

## Verification
The hardest case to reach from the ports is a packing overrun, where the requested sizes add up to more than 8 KB. In that case later sockets collapse to size 0, and a socket can start inside the window but reach past it. The stimulus writes size bytes such as 0xFF, 0x1B and 0xE4 to both registers and also writes decoy addresses next to them. It then drives pseudorandom pointers, so that masked write pointers often fall below masked read pointers and the wrap case is exercised. A behavioural model recomputes each slice and count from integers on every cycle.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int FIELD_W       = 2;
  localparam int MIN_BUF_BYTES = 1024;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } sbm_dir_e;
endpackage

// File: rtl/sbm_partition.sv
module sbm_partition
  import sbm_pkg::*;
#(
  parameter int             NSOCK  = 4,
  parameter int             AW     = 16,
  parameter logic [AW-1:0]  START  = 16'h4000,
  parameter int             REGION = 8192
) (
  input  logic [FIELD_W*NSOCK-1:0]  cfg,
  output logic [NSOCK-1:0][AW-1:0]  base,
  output logic [NSOCK-1:0][AW-1:0]  size
);
  localparam int            RW    = AW + 3;
  localparam logic [RW-1:0] END_R = RW'(START) + RW'(REGION);

  logic [NSOCK-1:0][RW-1:0] run;

  assign run[0] = RW'(START);

  for (genvar g = 0; g < NSOCK; g++) begin : g_slot
    logic [AW-1:0] req;
    logic          fits;
    assign req     = AW'(MIN_BUF_BYTES) << cfg[g*FIELD_W +: FIELD_W];
    assign fits    = run[g] < END_R;
    assign size[g] = fits ? req : '0;
    assign base[g] = fits ? run[g][AW-1:0] : END_R[AW-1:0];
    if (g < NSOCK - 1) begin : g_chain
      assign run[g+1] = run[g] + RW'(size[g]);
    end
  end
endmodule

// File: rtl/sbm_occupancy.sv
module sbm_occupancy #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] size,
  input  logic [AW-1:0] rd_ptr,
  input  logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] present,
  output logic [AW-1:0] room
);
  logic [AW-1:0] mask;

  always_comb begin
    mask    = size - AW'(1);
    present = (size == '0) ? '0 : ((wr_ptr - rd_ptr) & mask);
    room    = size - present;
  end
endmodule

// File: rtl/sockbuf_map.sv
module sockbuf_map
  import sbm_pkg::*;
#(
  parameter int            NSOCK       = 4,
  parameter int            AW          = 16,
  parameter logic [AW-1:0] TX_START    = 16'h4000,
  parameter logic [AW-1:0] RX_START    = 16'h6000,
  parameter int            REGION      = 8192,
  parameter logic [AW-1:0] RX_CFG_ADDR = 16'h001A,
  parameter logic [AW-1:0] TX_CFG_ADDR = 16'h001B,
  parameter logic [31:0]   CFG_RESET   = 32'h55,
  localparam int           CFG_W       = FIELD_W * NSOCK,
  localparam int           SEL_W       = $clog2(NSOCK)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic [NSOCK*AW-1:0] tx_rd_ptr,
  input  logic [NSOCK*AW-1:0] tx_wr_ptr,
  input  logic [NSOCK*AW-1:0] rx_rd_ptr,
  input  logic [NSOCK*AW-1:0] rx_wr_ptr,
  input  logic [NSOCK-1:0]    recv_cmd,
  input  logic [SEL_W-1:0]    xlat_sel,
  input  logic                xlat_rx,
  input  logic [AW-1:0]       xlat_ptr,
  output logic [NSOCK*AW-1:0] tx_base,
  output logic [NSOCK*AW-1:0] tx_size,
  output logic [NSOCK*AW-1:0] rx_base,
  output logic [NSOCK*AW-1:0] rx_size,
  output logic [NSOCK*AW-1:0] tx_free,
  output logic [NSOCK*AW-1:0] rx_rsr,
  output logic [AW-1:0]       xlat_addr
);
  localparam logic [AW-1:0] TX_END = TX_START + AW'(REGION);
  localparam logic [AW-1:0] RX_END = RX_START + AW'(REGION);

  logic [CFG_W-1:0] tx_cfg_q, tx_cfg_d, rx_cfg_q, rx_cfg_d;
  logic [NSOCK-1:0][AW-1:0] tx_base_w, tx_size_w, rx_base_w, rx_size_w;
  logic [NSOCK-1:0][AW-1:0] tx_present_w, tx_room_w, rx_present_w, rx_room_w;
  logic [NSOCK-1:0][AW-1:0] rsr_q, rsr_d;

  // configuration registers: next state
  always_comb begin
    tx_cfg_d = tx_cfg_q;
    rx_cfg_d = rx_cfg_q;
    if (cfg_we && cfg_addr == TX_CFG_ADDR) tx_cfg_d = cfg_wdata;
    if (cfg_we && cfg_addr == RX_CFG_ADDR) rx_cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cfg_q <= CFG_W'(CFG_RESET);
      rx_cfg_q <= CFG_W'(CFG_RESET);
    end else begin
      tx_cfg_q <= tx_cfg_d;
      rx_cfg_q <= rx_cfg_d;
    end
  end

  sbm_partition #(.NSOCK(NSOCK), .AW(AW), .START(TX_START), .REGION(REGION)) u_tx_part (
    .cfg(tx_cfg_q), .base(tx_base_w), .size(tx_size_w));

  sbm_partition #(.NSOCK(NSOCK), .AW(AW), .START(RX_START), .REGION(REGION)) u_rx_part (
    .cfg(rx_cfg_q), .base(rx_base_w), .size(rx_size_w));

  for (genvar g = 0; g < NSOCK; g++) begin : g_sock
    sbm_occupancy #(.AW(AW)) u_tx_occ (
      .size(tx_size_w[g]), .rd_ptr(tx_rd_ptr[g*AW +: AW]), .wr_ptr(tx_wr_ptr[g*AW +: AW]),
      .present(tx_present_w[g]), .room(tx_room_w[g]));
    sbm_occupancy #(.AW(AW)) u_rx_occ (
      .size(rx_size_w[g]), .rd_ptr(rx_rd_ptr[g*AW +: AW]), .wr_ptr(rx_wr_ptr[g*AW +: AW]),
      .present(rx_present_w[g]), .room(rx_room_w[g]));

    assign tx_base[g*AW +: AW] = tx_base_w[g];
    assign tx_size[g*AW +: AW] = tx_size_w[g];
    assign rx_base[g*AW +: AW] = rx_base_w[g];
    assign rx_size[g*AW +: AW] = rx_size_w[g];
    assign tx_free[g*AW +: AW] = tx_room_w[g];
    assign rx_rsr[g*AW +: AW]  = rsr_q[g];

    // R3: every slice size is zero or a single power of two
    p_pow2_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_size_w[g]) && $onehot0(rx_size_w[g]));
    // R5: collapsed sockets sit at the window end
    p_zero_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_size_w[g] == '0) |-> (tx_base_w[g] == TX_END));
    p_rx_zero_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_size_w[g] == '0) |-> (rx_base_w[g] == RX_END));
    // R6: counts never exceed the slice
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_room_w[g] <= tx_size_w[g]) && (tx_present_w[g] <= tx_size_w[g])
      && (rx_room_w[g] <= rx_size_w[g]));
    // R7: received size only moves on a receive command
    p_rsr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !recv_cmd[g] |=> $stable(rsr_q[g]));
    if (g > 0) begin : g_chain_chk
      // R4: a live slice begins where its predecessor ends
      p_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_size_w[g] != '0) |-> (rx_base_w[g] == rx_base_w[g-1] + rx_size_w[g-1]));
    end
  end

  // received-size registers: next state with explicit enable
  always_comb begin
    for (int i = 0; i < NSOCK; i++) begin
      rsr_d[i] = recv_cmd[i] ? rx_present_w[i] : rsr_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsr_q <= '0;
    else        rsr_q <= rsr_d;
  end

  // pointer to physical address
  logic [AW-1:0] xl_base, xl_size;
  always_comb begin
    if (sbm_dir_e'(xlat_rx) == DIR_RX) begin
      xl_base = rx_base_w[xlat_sel];
      xl_size = rx_size_w[xlat_sel];
    end else begin
      xl_base = tx_base_w[xlat_sel];
      xl_size = tx_size_w[xlat_sel];
    end
    xlat_addr = (xl_size == '0) ? xl_base : xl_base + (xlat_ptr & (xl_size - AW'(1)));
  end

  // R2: size registers change only on a matching write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && (cfg_addr == TX_CFG_ADDR || cfg_addr == RX_CFG_ADDR))
      |=> ($stable(tx_cfg_q) && $stable(rx_cfg_q)));
  // R8: translated address stays within the chosen slice
  p_xlat_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_size != '0) |-> (xlat_addr >= xl_base && (xlat_addr - xl_base) < xl_size));
endmodule

// File: tb/sockbuf_map_bench.sv
module sockbuf_map_bench;
  localparam int N  = 4;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [15:0] cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [N*AW-1:0] tx_rd_ptr, tx_wr_ptr, rx_rd_ptr, rx_wr_ptr;
  logic [N-1:0] recv_cmd;
  logic [1:0]   xlat_sel;
  logic         xlat_rx;
  logic [15:0]  xlat_ptr;
  logic [N*AW-1:0] tx_base, tx_size, rx_base, rx_size, tx_free, rx_rsr;
  logic [15:0]  xlat_addr;

  always #4 clk = ~clk;

  sockbuf_map u_sockbuf_map (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .tx_rd_ptr(tx_rd_ptr), .tx_wr_ptr(tx_wr_ptr), .rx_rd_ptr(rx_rd_ptr), .rx_wr_ptr(rx_wr_ptr),
    .recv_cmd(recv_cmd), .xlat_sel(xlat_sel), .xlat_rx(xlat_rx), .xlat_ptr(xlat_ptr),
    .tx_base(tx_base), .tx_size(tx_size), .rx_base(rx_base), .rx_size(rx_size),
    .tx_free(tx_free), .rx_rsr(rx_rsr), .xlat_addr(xlat_addr));

  int vectors = 0;
  int miscompares = 0;
  int m_txcfg, m_rxcfg;
  int m_rsr [N];
  int unsigned seed = 32'h1234_5678;
  string phase = "";

  function automatic int f_size(int cfg, int s);
    int b = 0;
    int sz = 0;
    for (int j = 0; j <= s; j++) begin
      sz = 1024 << ((cfg >> (2*j)) & 3);
      if (b >= 8192) sz = 0;
      if (j < s) b += sz;
    end
    return sz;
  endfunction

  function automatic int f_base(int cfg, int s, int start);
    int b = 0;
    for (int j = 0; j < s; j++) begin
      if (b < 8192) b += 1024 << ((cfg >> (2*j)) & 3);
    end
    return (b >= 8192) ? start + 8192 : start + b;
  endfunction

  function automatic int f_present(int sz, int rd, int wr);
    if (sz == 0) return 0;
    return ((wr % sz) - (rd % sz) + sz) % sz;
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  function automatic int fld(logic [N*AW-1:0] v, int i);
    return int'(v[i*AW +: AW]);
  endfunction

  // reference model state update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_txcfg = 'h55;
      m_rxcfg = 'h55;
      for (int i = 0; i < N; i++) m_rsr[i] = 0;
    end else begin
      for (int i = 0; i < N; i++)
        if (recv_cmd[i])
          m_rsr[i] = f_present(f_size(m_rxcfg, i), fld(rx_rd_ptr, i), fld(rx_wr_ptr, i));
      if (cfg_we && cfg_addr == 16'h001B) m_txcfg = int'(cfg_wdata);
      if (cfg_we && cfg_addr == 16'h001A) m_rxcfg = int'(cfg_wdata);
    end
  end

  task automatic check(string tag, int s, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s%s socket %0d: got %h expected %h", phase, tag, s, got, exp);
    end
  endtask

  task automatic compare_all();
    int tsz, rsz, xb, xs, xe;
    for (int i = 0; i < N; i++) begin
      tsz = f_size(m_txcfg, i);
      rsz = f_size(m_rxcfg, i);
      check((tsz == 0) ? "R5 tx size" : "R3 tx size", i, fld(tx_size, i), tsz);
      check((rsz == 0) ? "R5 rx size" : "R3 rx size", i, fld(rx_size, i), rsz);
      check((tsz == 0) ? "R5 tx base" : "R4 tx base", i, fld(tx_base, i), f_base(m_txcfg, i, 'h4000));
      check((rsz == 0) ? "R5 rx base" : "R4 rx base", i, fld(rx_base, i), f_base(m_rxcfg, i, 'h6000));
      check("R6 tx free", i, fld(tx_free, i), tsz - f_present(tsz, fld(tx_rd_ptr, i), fld(tx_wr_ptr, i)));
      check("R7 rx rsr", i, fld(rx_rsr, i), m_rsr[i]);
    end
    if (xlat_rx) begin
      xb = f_base(m_rxcfg, int'(xlat_sel), 'h6000);
      xs = f_size(m_rxcfg, int'(xlat_sel));
    end else begin
      xb = f_base(m_txcfg, int'(xlat_sel), 'h4000);
      xs = f_size(m_txcfg, int'(xlat_sel));
    end
    xe = (xs == 0) ? xb : (xb + (int'(xlat_ptr) % xs)) & 'hFFFF;
    check("R8 xlat", int'(xlat_sel), int'(xlat_addr), xe);
  endtask

  task automatic randomize_inputs();
    for (int i = 0; i < N; i++) begin
      tx_rd_ptr[i*AW +: AW] = 16'(rnd());
      tx_wr_ptr[i*AW +: AW] = 16'(rnd());
      rx_rd_ptr[i*AW +: AW] = 16'(rnd());
      rx_wr_ptr[i*AW +: AW] = 16'(rnd());
    end
    recv_cmd = 4'(rnd());
    xlat_sel = 2'(rnd());
    xlat_rx  = 1'(rnd());
    xlat_ptr = 16'(rnd());
  endtask

  task automatic step_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    recv_cmd = '0;
    #1 compare_all();
    @(negedge clk);
    cfg_we = 1'b0;
    #1 compare_all();
  endtask

  task automatic step_random();
    @(negedge clk);
    cfg_we = 1'b0;
    randomize_inputs();
    #1 compare_all();
  endtask

  initial begin
    byte cfgs [7] = '{8'h55, 8'h00, 8'hFF, 8'h1B, 8'hE4, 8'hAA, 8'h39};
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tx_rd_ptr = '0; tx_wr_ptr = '0; rx_rd_ptr = '0; rx_wr_ptr = '0;
    recv_cmd = '0; xlat_sel = '0; xlat_rx = 1'b0; xlat_ptr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset partition and cleared received sizes
    phase = "R1 ";
    @(negedge clk); #1 compare_all();
    xlat_rx = 1'b1; xlat_sel = 2'd3; xlat_ptr = 16'hFFFF;
    #1 compare_all();
    phase = "";
    for (int c = 0; c < 7; c++) begin
      step_write(16'h001B, cfgs[c]);
      step_write(16'h001A, ~cfgs[c]);
      // R2: decoy writes next to and aliasing the size registers
      phase = "R2 ";
      step_write(16'h0019, 8'(rnd()));
      step_write(16'h011A, 8'(rnd()));
      step_write(16'h001C, 8'(rnd()));
      phase = "";
      for (int k = 0; k < 40; k++) step_random();
    end
    // R7: hold with no receive command while pointers keep moving
    for (int k = 0; k < 10; k++) begin
      step_random();
      recv_cmd = '0;
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule